// File: doc/BRIEF.md
# AES Key-Expansion Assist Unit

This unit computes the helper value that software combines with earlier round-key words to build AES round keys. A 128-bit source splits into four 32-bit lanes, with lane 0 in bits 31:0 and lane 3 in bits 127:96. Only lanes 1 and 3 contribute. Each of these two lanes passes through the AES forward S-box one byte at a time. The substituted word is placed in one output lane. A copy of the same word, rotated right by eight bits and XORed with the zero-extended 8-bit round constant, fills the lane above it.

The result is a 256-bit register write. With the legacy encoding, the upper 128 bits carry the register's previous upper half, which arrives on its own port. With the extended encoding, the upper half is cleared. Under the extended encoding, a 4-bit reserved operand field must read all ones. Any other value raises an undefined-encoding flag and blanks the write.

Items enter on a valid/ready stream and leave on a valid/ready stream after one register stage. An item is taken on a clock edge where `in_valid` and `in_ready` are both high, and delivered on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. While `out_ready` is low, the held result stays unchanged and no new item is accepted. The upstream side may hold or drop `in_valid` as it wishes. The downstream side may stall for any number of cycles.

Top module: `akg_assist_unit`

## Requirements
- R1: Result bits 31:0 hold the AES forward S-box applied to each byte of source lane 1, and bits 95:64 hold the same for lane 3, with the byte position kept.
- R2: Result bits 63:32 equal the substituted lane 1 rotated right by 8 bits ({w[7:0], w[31:8]}) XOR the zero-extended constant. Bits 127:96 are formed the same way from lane 3. The constant lands in bits 39:32 and 103:96.
- R3: Source lanes 0 (bits 31:0) and 2 (bits 95:64) have no effect on any output.
- R4: With `ext_mode` = 0, result bits 255:128 equal `old_upper` as sampled at acceptance, and `ud` is 0 whatever `rsv_field` holds.
- R5: With `ext_mode` = 1 and `rsv_field` = 4'b1111, result bits 255:128 are zero and `ud` is 0.
- R6: With `ext_mode` = 1 and `rsv_field` other than 4'b1111, `ud` is 1 and all 256 result bits are zero.
- R7: An item accepted on one edge raises `out_valid` with its result after that edge. Results leave in acceptance order, one per accepted item.
- R8: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `dest` and `ud` hold their values.
- R9: During and straight after reset, `out_valid`, `ud` and `dest` are all zero.
- R10: For the standard 128-bit test key 2b7e1516 28aed2a6 abf71588 09cf4f3c, loaded little-endian per lane, with constant 0x01, result bits 127:96 equal 0x01eb848b. XOR-ing them with lane 0 gives 0x17fefaa0, which is the first word of the next round key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source item offered |
| in_ready | output | 1 | Unit can take the offered item |
| src | input | 128 | Four 32-bit source lanes |
| imm8 | input | 8 | Round constant |
| ext_mode | input | 1 | 1 selects the extended encoding (upper half cleared) |
| rsv_field | input | 4 | Reserved operand field, checked under the extended encoding |
| old_upper | input | 128 | Previous upper half of the destination register |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the held result |
| dest | output | 256 | Register write value |
| ud | output | 1 | Undefined-encoding flag for the held result |

## Verification
The assertions assume that `out_ready` is a plain level sampled at the clock edge. They also assume that `src`, `imm8`, `ext_mode`, `rsv_field` and `old_upper` are settled whenever `in_valid` is high at an edge, because the checks on the upper half compare against the values present at acceptance. The stimulus drives every input just after the falling edge and samples outputs shortly before the rising edge, so each handshake is decided on stable levels. The consumer side runs first with `out_ready` tied high and then with a pseudo-random pattern, which exercises stalls of varying length and back-to-back transfers.

// File: rtl/akg_pkg.sv
package akg_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANE_W  = 32;
  localparam int LANES   = 4;
  localparam int SRC_W   = LANE_W * LANES;
  localparam int REG_W   = 2 * SRC_W;
  localparam int RSV_W   = 4;
  localparam int LANE_BYTES = LANE_W / BYTE_W;
  localparam logic [BYTE_W-1:0] AFFINE_C = 8'h63;
  localparam logic [BYTE_W-1:0] POLY_LO  = 8'h1b;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic             ud;
    logic [REG_W-1:0] data;
  } wr_result_t;

  // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1.
  function automatic logic [BYTE_W-1:0] gf_xtime(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? POLY_LO : '0);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // Rotate a lane right by one byte.
  function automatic lane_t rotr_byte(input lane_t w);
    return {w[BYTE_W-1:0], w[LANE_W-1:BYTE_W]};
  endfunction
endpackage

// File: rtl/akg_sbox.sv
module akg_sbox
  import akg_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  logic [BYTE_W-1:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252, inv;
  logic [BYTE_W-1:0] aff;

  // Inverse as din^254 by an addition chain; zero maps to zero.
  always_comb begin
    p2   = gf_mul(din, din);
    p3   = gf_mul(p2, din);
    p6   = gf_mul(p3, p3);
    p12  = gf_mul(p6, p6);
    p15  = gf_mul(p12, p3);
    p30  = gf_mul(p15, p15);
    p60  = gf_mul(p30, p30);
    p120 = gf_mul(p60, p60);
    p240 = gf_mul(p120, p120);
    p252 = gf_mul(p240, p12);
    inv  = gf_mul(p252, p2);
  end

  always_comb begin
    aff = inv
        ^ {inv[6:0], inv[7]}
        ^ {inv[5:0], inv[7:6]}
        ^ {inv[4:0], inv[7:5]}
        ^ {inv[3:0], inv[7:4]};
    dout = aff ^ AFFINE_C;
  end
endmodule

// File: rtl/akg_subword.sv
module akg_subword
  import akg_pkg::*;
(
  input  lane_t win,
  output lane_t wout
);
  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
    akg_sbox u_sbox (
      .din  (win[b*BYTE_W +: BYTE_W]),
      .dout (wout[b*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/akg_lane_build.sv
module akg_lane_build
  import akg_pkg::*;
(
  input  logic [SRC_W-1:0]  src,
  input  logic [BYTE_W-1:0] rcon,
  output logic [SRC_W-1:0]  helper
);
  localparam int PAIRS = LANES / 2;
  lane_t rcon_w;

  assign rcon_w = lane_t'(rcon);

  // Each pair of output lanes draws on the odd source lane of that pair.
  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    lane_t sub_w;
    akg_subword u_sub (
      .win  (src[(2*k+1)*LANE_W +: LANE_W]),
      .wout (sub_w)
    );
    assign helper[(2*k)*LANE_W   +: LANE_W] = sub_w;
    assign helper[(2*k+1)*LANE_W +: LANE_W] = rotr_byte(sub_w) ^ rcon_w;
  end
endmodule

// File: rtl/akg_upper_merge.sv
module akg_upper_merge
  import akg_pkg::*;
(
  input  logic [SRC_W-1:0] helper,
  input  logic             ext_mode,
  input  logic [RSV_W-1:0] rsv_field,
  input  logic [SRC_W-1:0] old_upper,
  output wr_result_t       res
);
  logic             bad_enc;
  logic [SRC_W-1:0] upper;

  assign bad_enc = ext_mode && (rsv_field != {RSV_W{1'b1}});
  assign upper   = ext_mode ? '0 : old_upper;

  always_comb begin
    res.ud   = bad_enc;
    res.data = bad_enc ? '0 : {upper, helper};
  end
endmodule

// File: rtl/akg_assist_unit.sv
module akg_assist_unit
  import akg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  src,
  input  logic [BYTE_W-1:0] imm8,
  input  logic              ext_mode,
  input  logic [RSV_W-1:0]  rsv_field,
  input  logic [SRC_W-1:0]  old_upper,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REG_W-1:0]  dest,
  output logic              ud
);
  logic [SRC_W-1:0] helper;
  wr_result_t       nxt;
  wr_result_t       held_q;
  logic             vld_q;
  logic             take;

  akg_lane_build u_build (
    .src    (src),
    .rcon   (imm8),
    .helper (helper)
  );

  akg_upper_merge u_merge (
    .helper    (helper),
    .ext_mode  (ext_mode),
    .rsv_field (rsv_field),
    .old_upper (old_upper),
    .res       (nxt)
  );

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      held_q <= '0;
    end else begin
      if (in_ready) vld_q <= in_valid;
      if (take)     held_q <= nxt;
    end
  end

  assign out_valid = vld_q;
  assign dest      = held_q.data;
  assign ud        = held_q.ud;
endmodule

// File: rtl/akg_assist_chk.sv
module akg_assist_chk
  import akg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              ext_mode,
  input logic [RSV_W-1:0]  rsv_field,
  input logic [SRC_W-1:0]  old_upper,
  input logic              out_valid,
  input logic              out_ready,
  input logic [REG_W-1:0]  dest,
  input logic              ud
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !(out_valid && !out_ready)) |=> !out_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dest) && $stable(ud)));

  a_r8_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r4_legacy_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ext_mode) |=> (dest[REG_W-1:SRC_W] == $past(old_upper) && !ud));

  a_r5_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ext_mode && rsv_field == {RSV_W{1'b1}}) |=> (dest[REG_W-1:SRC_W] == '0 && !ud));

  a_r6_ud_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ext_mode && rsv_field != {RSV_W{1'b1}}) |=> ud);

  a_r6_ud_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ud) |-> dest == '0);

  a_r9_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !ud && dest == '0));
endmodule

bind akg_assist_unit akg_assist_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .ext_mode  (ext_mode),
  .rsv_field (rsv_field),
  .old_upper (old_upper),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .dest      (dest),
  .ud        (ud)
);

// File: tb/tb_akg_assist_unit.sv
module tb_akg_assist_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src = '0;
  logic [7:0]   imm8 = '0;
  logic         ext_mode = 1'b0;
  logic [3:0]   rsv_field = '0;
  logic [127:0] old_upper = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [255:0] dest;
  logic         ud;

  int n_checks = 0;
  int n_fail   = 0;
  bit stall_mode = 1'b0;
  logic [15:0] lfsr = 16'hace1;

  logic [7:0]   sb [256];
  logic [256:0] exp_q [$];
  logic [256:0] got_q [$];

  always #5 clk = ~clk;

  akg_assist_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .imm8(imm8), .ext_mode(ext_mode), .rsv_field(rsv_field),
    .old_upper(old_upper), .out_valid(out_valid), .out_ready(out_ready),
    .dest(dest), .ud(ud)
  );

  task automatic check(input bit ok, input string req,
                       input logic [256:0] act, input logic [256:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Forward S-box built from a generator walk, independent of the design.
  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  initial begin
    logic [7:0] p, q;
    p = 8'h01;
    q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  end

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  function automatic logic [256:0] model(input logic [127:0] s, input logic [7:0] k,
                                         input logic m, input logic [3:0] r,
                                         input logic [127:0] up);
    logic [31:0] a, b;
    logic [127:0] low;
    a = subw(s[63:32]);
    b = subw(s[127:96]);
    low = {({b[7:0], b[31:8]} ^ {24'h0, k}), b, ({a[7:0], a[31:8]} ^ {24'h0, k}), a};
    if (m && r != 4'hf) return {1'b1, 256'h0};
    return {1'b0, (m ? 128'h0 : up), low};
  endfunction

  task automatic send(input logic [127:0] s, input logic [7:0] k, input logic m,
                      input logic [3:0] r, input logic [127:0] up);
    @(negedge clk);
    #1;
    in_valid = 1'b1; src = s; imm8 = k; ext_mode = m; rsv_field = r; old_upper = up;
    forever begin
      #3;
      if (in_ready) break;
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(s, k, m, r, up));
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  // Consumer ready pattern.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall_mode ? lfsr[0] : 1'b1;
    end
  end

  // Monitor: scoreboard compare, stall stability.
  initial begin
    bit prev_stall = 1'b0;
    logic [256:0] prev_d = '0;
    logic [256:0] e;
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        if (prev_stall)
          check(out_valid && {ud, dest} == prev_d, "R8 held while stalled", {ud, dest}, prev_d);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 result without accepted item", {ud, dest}, '0);
          end else begin
            e = exp_q.pop_front();
            check({ud, dest} === e, "R1 R2 R4 R5 R6 R7 result", {ud, dest}, e);
          end
          got_q.push_back({ud, dest});
        end
        check(in_ready == (!out_valid || out_ready), "R8 ready rule",
              {256'h0, in_ready}, {256'h0, (!out_valid || out_ready)});
        prev_stall = out_valid && !out_ready;
        prev_d = {ud, dest};
      end
    end
  end

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog expired", '0, '0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [127:0] key;
    logic [31:0]  w4;
    repeat (4) @(negedge clk);
    #3;
    check(out_valid == 1'b0, "R9 reset out_valid", {256'h0, out_valid}, '0);
    check(ud == 1'b0, "R9 reset ud", {256'h0, ud}, '0);
    check(dest == '0, "R9 reset dest", {1'b0, dest}, '0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;

    key = {32'h3c4fcf09, 32'h8815f7ab, 32'ha6d2ae28, 32'h16157e2b};
    send(key, 8'h01, 1'b0, 4'h0, 128'h0123456789abcdef_fedcba9876543210); // got 0, R10
    send('0, 8'h00, 1'b0, 4'hf, '1);                                      // got 1, R1
    send('1, 8'hff, 1'b1, 4'hf, '1);                                      // got 2, R5
    send(128'h11111111_aaaaaaaa_22222222_bbbbbbbb, 8'h36, 1'b0, 4'h3, 128'h5); // got 3, R3
    send(128'h11111111_55555555_22222222_66666666, 8'h36, 1'b0, 4'h3, 128'h5); // got 4, R3
    send(128'hdeadbeef_cafef00d_01234567_89abcdef, 8'h80, 1'b1, 4'h5, '1);     // got 5, R6
    send(128'hdeadbeef_cafef00d_01234567_89abcdef, 8'h1b, 1'b1, 4'h7, '0);     // got 6, R6
    send(128'hdeadbeef_cafef00d_01234567_89abcdef, 8'h1b, 1'b0, 4'h7, '1);     // got 7, R4

    stall_mode = 1'b1;
    for (int i = 0; i < 60; i++) begin
      send({$urandom, $urandom, $urandom, $urandom}, 8'($urandom), 1'($urandom),
           (($urandom % 3) == 0) ? 4'($urandom) : 4'hf,
           {$urandom, $urandom, $urandom, $urandom});
    end
    stall_mode = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    check(got_q.size() == 68, "R7 one result per item", {225'h0, 32'(got_q.size())}, 257'd68);
    w4 = got_q[0][127:96];
    check(w4 == 32'h01eb848b, "R10 assist word", {225'h0, w4}, {225'h0, 32'h01eb848b});
    check((w4 ^ key[31:0]) == 32'h17fefaa0, "R10 next round-key word",
          {225'h0, w4 ^ key[31:0]}, {225'h0, 32'h17fefaa0});
    check(got_q[1][127:0] == {4{32'h63636363}}, "R1 zero source",
          {129'h0, got_q[1][127:0]}, {129'h0, {4{32'h63636363}}});
    check(got_q[3] == got_q[4], "R3 lanes 0 and 2 ignored", got_q[4], got_q[3]);
    check(got_q[5] == {1'b1, 256'h0}, "R6 undefined encoding blanks write",
          got_q[5], {1'b1, 256'h0});
    check(got_q[2][255:128] == '0 && !got_q[2][256], "R5 upper cleared",
          {1'b0, got_q[2][255:0]}, {1'b0, 128'h0, got_q[2][127:0]});
    check(got_q[7][255:128] == '1 && !got_q[7][256], "R4 upper kept, rsv ignored",
          got_q[7], {1'b0, {128{1'b1}}, got_q[7][127:0]});

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule